// File: doc/BRIEF.md
# I2C Controller Interrupt Combiner

This block merges the status events of an I2C controller into a single interrupt request. Four event pulses come from the protocol engine: arbitration lost, byte transfer complete, addressed as slave, and acknowledge missing. The engine also supplies the bus-busy level. The block turns the falling edge of bus-busy into a fifth cause, bus idle. That cause counts only while a separate idle enable bit is set.

Any active cause sets one shared interrupt flag and a sticky status bit for that cause. Software reads the status bits to find out why the interrupt fired. Software clears the flag by writing a one to it. The request line is the flag gated by a global enable. A small write port selects between a control register and a status register.

Top module: `i2c_irq_combiner`

## Requirements
- R1: `irq` is high exactly when `irq_flag` is high and the global enable is set. The flag is still set while the global enable is clear.
- R2: A one-cycle pulse on `ev_arb_lost`, `ev_xfer_done`, `ev_addr_match` or `ev_no_ack` sets `irq_flag`. The same pulse sets `cause[0]`, `cause[1]`, `cause[2]` or `cause[3]` respectively. The new values are visible one clock after the pulse is sampled.
- R3: Cause bits are sticky until the flag is cleared. Causes that arrive while the flag is already set are added to the bits already held.
- R4: A write with `wr_addr`=1 and `wr_data[1]`=1 clears `irq_flag`, `irq` and every cause bit on the next clock.
- R5: A write with `wr_addr`=1 and `wr_data[1]`=0 changes neither the flag nor the cause bits.
- R6: An event in the same cycle as a clear write leaves the flag set. Only that event's cause bit remains, and the other cause bits clear.
- R7: While the idle enable is set, a high-to-low change of `bus_busy` sets the flag and `cause[4]` once. A rising edge does not set them, and neither does `bus_busy` held low.
- R8: While the idle enable is clear, a falling edge of `bus_busy` does not set the flag or `cause[4]`.
- R9: A write with `wr_addr`=0 loads the global enable from `wr_data[7]` and the idle enable from `wr_data[6]`.
- R10: Synchronous reset clears the flag, the cause bits and both enables, and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_xfer_done | input | 1 | Byte transfer complete pulse |
| ev_addr_match | input | 1 | Addressed as slave pulse |
| ev_no_ack | input | 1 | Expected acknowledge missing pulse |
| bus_busy | input | 1 | Bus busy level from the protocol engine |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (1) | 0 = control register, 1 = status register |
| wr_data | input | DATA_W (8) | Write data |
| irq | output | 1 | Registered interrupt request |
| irq_flag | output | 1 | Shared interrupt flag |
| cause | output | 5 | Sticky cause bits, indexed as in R2 and R7 |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 1-bit address, and the enable and flag bits at positions 7, 6 and 1. With these values every register bit the requirements name can be reached from the bench's write vectors. The vector table drives the event pulses, clear writes and bus-busy edges in sequences that exercise the collision between an event and a clear. It also covers the idle cause with its enable clear and then set, and combined causes. Directed steps then apply reset while the interrupt is active, and afterwards confirm that both enables came back clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_CAUSES = 5;
  typedef enum int {
    CAUSE_ARB   = 0,
    CAUSE_XFER  = 1,
    CAUSE_ADDR  = 2,
    CAUSE_NOACK = 3,
    CAUSE_IDLE  = 4
  } cause_e;
endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign fall = prev_q & ~level;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] status
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)             bit_q <= 1'b0;
        else if (set_vec[g]) bit_q <= 1'b1;
        else if (clr)        bit_q <= 1'b0;
      end
      assign status[g] = bit_q;
    end
  endgenerate
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int ADDR_W      = 1,
  parameter int DATA_W      = 8,
  parameter int CTRL_ADDR   = 0,
  parameter int STAT_ADDR   = 1,
  parameter int IE_BIT      = 7,
  parameter int IDLE_IE_BIT = 6,
  parameter int FLAG_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              any_set,
  output logic              clr,
  output logic              idle_ie,
  output logic              flag,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic ie_q, idle_ie_q, flag_q, irq_q;
  logic ie_d, idle_ie_d, flag_d, ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == CTRL_A);
  assign clr     = wr_en && (wr_addr == STAT_A) && wr_data[FLAG_BIT];

  always_comb begin
    ie_d      = ctrl_wr ? wr_data[IE_BIT]      : ie_q;
    idle_ie_d = ctrl_wr ? wr_data[IDLE_IE_BIT] : idle_ie_q;
    flag_d    = any_set | (flag_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      idle_ie_q <= 1'b0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      ie_q      <= ie_d;
      idle_ie_q <= idle_ie_d;
      flag_q    <= flag_d;
      irq_q     <= flag_d & ie_d;
    end
  end

  logic unused_data;
  assign unused_data = ^wr_data;

  assign idle_ie = idle_ie_q;
  assign flag    = flag_q;
  assign irq     = irq_q;
endmodule

// File: rtl/i2c_irq_combiner.sv
module i2c_irq_combiner
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 1,
  parameter int DATA_W      = 8,
  parameter int CTRL_ADDR   = 0,
  parameter int STAT_ADDR   = 1,
  parameter int IE_BIT      = 7,
  parameter int IDLE_IE_BIT = 6,
  parameter int FLAG_BIT    = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_arb_lost,
  input  logic                  ev_xfer_done,
  input  logic                  ev_addr_match,
  input  logic                  ev_no_ack,
  input  logic                  bus_busy,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  irq,
  output logic                  irq_flag,
  output logic [NUM_CAUSES-1:0] cause
);
  logic                  busy_fall, idle_ie, idle_ev, clr_w, any_set;
  logic [NUM_CAUSES-1:0] set_vec;

  irq_fall_det u_fall (
    .clk   (clk),
    .rst   (rst),
    .level (bus_busy),
    .fall  (busy_fall)
  );

  assign idle_ev = busy_fall & idle_ie;

  always_comb begin
    set_vec              = '0;
    set_vec[CAUSE_ARB]   = ev_arb_lost;
    set_vec[CAUSE_XFER]  = ev_xfer_done;
    set_vec[CAUSE_ADDR]  = ev_addr_match;
    set_vec[CAUSE_NOACK] = ev_no_ack;
    set_vec[CAUSE_IDLE]  = idle_ev;
  end

  assign any_set = |set_vec;

  irq_ctrl_regs #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CTRL_ADDR   (CTRL_ADDR),
    .STAT_ADDR   (STAT_ADDR),
    .IE_BIT      (IE_BIT),
    .IDLE_IE_BIT (IDLE_IE_BIT),
    .FLAG_BIT    (FLAG_BIT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .any_set (any_set),
    .clr     (clr_w),
    .idle_ie (idle_ie),
    .flag    (irq_flag),
    .irq     (irq)
  );

  irq_cause_bank #(.N(NUM_CAUSES)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr     (clr_w),
    .status  (cause)
  );
endmodule

// File: rtl/i2c_irq_combiner_chk.sv
module i2c_irq_combiner_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         ev_arb_lost,
  input logic         ev_xfer_done,
  input logic         ev_addr_match,
  input logic         ev_no_ack,
  input logic         idle_ev,
  input logic         clr_w,
  input logic         irq,
  input logic         irq_flag,
  input logic [N-1:0] cause
);
  logic raw_any;
  assign raw_any = ev_arb_lost | ev_xfer_done | ev_addr_match | ev_no_ack;

  // R1
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_flag);

  // R2
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    raw_any |=> irq_flag);

  // R2
  arb_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> cause[0]);

  // R4
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !raw_any && !idle_ev) |=> (!irq_flag && !irq && cause == '0));

  // R5
  flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !clr_w) |=> irq_flag);

  // R6
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_w && raw_any) |=> irq_flag);

  // R7
  idle_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
    idle_ev |=> (cause[N-1] && irq_flag));

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq && !irq_flag && cause == '0));
endmodule

bind i2c_irq_combiner i2c_irq_combiner_chk #(.N(irq_pkg::NUM_CAUSES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_arb_lost   (ev_arb_lost),
  .ev_xfer_done  (ev_xfer_done),
  .ev_addr_match (ev_addr_match),
  .ev_no_ack     (ev_no_ack),
  .idle_ev       (idle_ev),
  .clr_w         (clr_w),
  .irq           (irq),
  .irq_flag      (irq_flag),
  .cause         (cause)
);

// File: tb/test_i2c_irq_combiner.sv
module test_i2c_irq_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_arb_lost = 0, ev_xfer_done = 0, ev_addr_match = 0, ev_no_ack = 0;
  logic       bus_busy = 0, wr_en = 0;
  logic [0:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq, irq_flag;
  logic [4:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_combiner i_i2c_irq_combiner (
    .clk(clk), .rst(rst),
    .ev_arb_lost(ev_arb_lost), .ev_xfer_done(ev_xfer_done),
    .ev_addr_match(ev_addr_match), .ev_no_ack(ev_no_ack),
    .bus_busy(bus_busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .irq_flag(irq_flag), .cause(cause)
  );

  // {wr_en, addr, data[8], ev{noack,addr,xfer,arb}, busy, flag, irq, cause[5]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 0 idle
    {1'b0, 1'b0, 8'h00, 4'b0001, 1'b0, 1'b1, 1'b0, 5'b00001}, // 1 arb, ie off
    {1'b1, 1'b0, 8'h80, 4'b0000, 1'b0, 1'b1, 1'b1, 5'b00001}, // 2 ie on
    {1'b1, 1'b1, 8'h00, 4'b0000, 1'b0, 1'b1, 1'b1, 5'b00001}, // 3 write 0
    {1'b1, 1'b1, 8'h02, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 4 clear
    {1'b0, 1'b0, 8'h00, 4'b0010, 1'b0, 1'b1, 1'b1, 5'b00010}, // 5 xfer
    {1'b1, 1'b1, 8'h02, 4'b0100, 1'b0, 1'b1, 1'b1, 5'b00100}, // 6 clear+addr
    {1'b1, 1'b1, 8'h02, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 7 clear
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b1, 1'b0, 1'b0, 5'b00000}, // 8 busy up
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 9 fall, idle ie off
    {1'b1, 1'b0, 8'hC0, 4'b0000, 1'b1, 1'b0, 1'b0, 5'b00000}, // 10 both ie, rise
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b1, 1'b1, 5'b10000}, // 11 fall -> idle
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b1, 1'b1, 5'b10000}, // 12 held low
    {1'b1, 1'b1, 8'h02, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 13 clear
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 14 held low again
    {1'b0, 1'b0, 8'h00, 4'b1000, 1'b0, 1'b1, 1'b1, 5'b01000}, // 15 noack
    {1'b1, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b1, 1'b0, 5'b01000}, // 16 ie off
    {1'b0, 1'b0, 8'h00, 4'b0011, 1'b0, 1'b1, 1'b0, 5'b01011}, // 17 arb+xfer add
    {1'b1, 1'b1, 8'h02, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000}, // 18 clear
    {1'b1, 1'b0, 8'h40, 4'b0000, 1'b1, 1'b0, 1'b0, 5'b00000}, // 19 idle ie, rise
    {1'b0, 1'b0, 8'h00, 4'b0000, 1'b0, 1'b1, 1'b0, 5'b10000}  // 20 fall, ie off
  };

  function automatic string vtag(int i);
    case (i)
      0:  return "R10";
      1:  return "R2";
      2:  return "R9";
      3:  return "R5";
      4:  return "R4";
      5:  return "R2";
      6:  return "R6";
      7:  return "R4";
      8:  return "R7";
      9:  return "R8";
      10: return "R7";
      11: return "R7";
      12: return "R7";
      13: return "R4";
      14: return "R7";
      15: return "R2";
      16: return "R1";
      17: return "R3";
      18: return "R4";
      19: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic f, logic q, logic [4:0] c);
    checks++;
    if (irq_flag !== f || irq !== q || cause !== c) begin
      failures++;
      $display("FAIL %s: flag=%b irq=%b cause=%b expected flag=%b irq=%b cause=%b",
               tag, irq_flag, irq, cause, f, q, c);
    end
  endtask

  task automatic idle_inputs();
    {ev_no_ack, ev_addr_match, ev_xfer_done, ev_arb_lost} = 4'b0000;
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bus_busy = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", 1'b0, 1'b0, 5'b00000);
    rst = 1'b0;
    bus_busy = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      wr_en    = v[21];
      wr_addr  = v[20];
      wr_data  = v[19:12];
      {ev_no_ack, ev_addr_match, ev_xfer_done, ev_arb_lost} = v[11:8];
      bus_busy = v[7];
      step();
      check(vtag(i), v[6], v[5], v[4:0]);
    end

    // Directed: reset while interrupt active (R10)
    idle_inputs();
    wr_en = 1; wr_addr = 1'b0; wr_data = 8'h80;
    step();
    idle_inputs();
    ev_arb_lost = 1;
    step();
    idle_inputs();
    check("R1", 1'b1, 1'b1, 5'b10001);
    rst = 1'b1;
    step();
    check("R10", 1'b0, 1'b0, 5'b00000);
    rst = 1'b0;
    // enables must be clear after reset (R10)
    ev_xfer_done = 1;
    step();
    idle_inputs();
    check("R10", 1'b1, 1'b0, 5'b00010);
    wr_en = 1; wr_addr = 1'b1; wr_data = 8'h02;
    step();
    idle_inputs();
    bus_busy = 1'b1;
    step();
    bus_busy = 1'b0;
    step();
    check("R10", 1'b0, 1'b0, 5'b00000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule